// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small CPU core and decides which interrupt, if any, the core should take next. It holds one pending flag per interrupt source. A parameter mask marks each source as latched or level-type. A latched source remembers a single-cycle event until the CPU takes its vector or software clears the flag. A level-type source requests only while its condition input is high. Pending requests are masked by per-source enables and by one global enable. The lowest-numbered request wins, and its vector address is driven to the core.

Vector slot 0 is reserved for reset. Source *i* uses vector slot *i+1*, and each slot is two words wide. The table sits at address 0, or at a boot base address when the base-select input is high. When the core acknowledges, the controller clears the global enable and clears the winning latched flag. A return strobe sets the global enable again. No new interrupt is then raised until the core reports that one more main-program instruction has retired.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `flags_o`, `irq_o` and `gie_o` are all 0.
- R2: `irq_o` is high only when at least one source is pending and enabled (`flags_o[i] & src_en_i[i]`) and the global enable is set.
- R3: When several sources are pending and enabled, the lowest index *i* wins. `vec_o` then equals base + 2·(i+1), where base is 0 when `boot_sel_i`=0 and `BOOT_BASE` when `boot_sel_i`=1.
- R4: A latched source's event sets its flag one clock later, even while the source or the global enable is disabled. The flag stays set until it is cleared.
- R5: When `ack_i` is high while `irq_o` is high, the winning latched flag clears on the next clock. Other flags are kept.
- R6: An accepted acknowledge clears `gie_o` on the next clock. `gie_set_i` sets `gie_o` on the next clock.
- R7: `reti_i` sets `gie_o` on the next clock. `irq_o` then stays low until one clock after an `instr_i` pulse.
- R8: `gie_clr_i` forces `irq_o` low in the same cycle, and `gie_o` is 0 from the next clock.
- R9: A 1 on bit *i* of `w1c_i` clears latched flag *i* on the next clock. If an event arrives in the same cycle, the flag stays set.
- R10: A level-type source's flag bit follows its condition input with no storage. A condition that goes away before the source is enabled leaves no request behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt_i | input | NSRC | Event pulse (latched) or condition level (level-type) per source |
| src_en_i | input | NSRC | Per-source enable |
| w1c_i | input | NSRC | Write-one-to-clear strobes for the flags |
| gie_set_i | input | 1 | Software sets the global enable |
| gie_clr_i | input | 1 | Software clears the global enable |
| ack_i | input | 1 | CPU takes the offered vector |
| reti_i | input | 1 | CPU executes return-from-interrupt |
| instr_i | input | 1 | One main-program instruction retired |
| boot_sel_i | input | 1 | Selects the boot vector base |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | AW | Vector address of the winning source |
| gie_o | output | 1 | Current global enable |
| flags_o | output | NSRC | Pending flags (live condition for level-type sources) |

## Verification
The bench builds the controller with four sources, a 10-bit address and a boot base of 0x300. Source 3 is level-type and the other three are latched. With only four sources, every combination of pending flags, enable bits and base selection can be swept: 512 cases, each compared against an arithmetic model of priority and vector address. Directed sequences then cover the acknowledge, return and one-instruction hold. They also cover a clear arriving together with an event, a same-cycle global clear, and a vanishing level condition.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  typedef enum logic {KIND_LATCH = 1'b0, KIND_LEVEL = 1'b1} src_kind_e;

  function automatic src_kind_e kind_of(input logic level_bit);
    return level_bit ? KIND_LEVEL : KIND_LATCH;
  endfunction

  // next value of a latched flag: an arriving event outranks any clear
  function automatic logic latch_next(input logic cur, input logic evt,
                                      input logic sw_clr, input logic hw_clr);
    return evt | (cur & ~sw_clr & ~hw_clr);
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import vec_irq_pkg::*;
#(
  parameter int NSRC = 8,
  parameter logic [NSRC-1:0] LEVEL_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] w1c_i,
  input  logic [NSRC-1:0] take_i,
  output logic [NSRC-1:0] pend_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (kind_of(LEVEL_MASK[i]) == KIND_LEVEL) begin : g_level
      assign pend_o[i] = evt_i[i];
    end else begin : g_latch
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= latch_next(flag_q, evt_i[i], w1c_i[i], take_i[i]);
      end
      assign pend_o[i] = flag_q;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NSRC = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req_i,
  output logic            any_o,
  output logic [IW-1:0]   idx_o,
  output logic [NSRC-1:0] grant_o
);
  always_comb begin
    idx_o   = '0;
    grant_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o   = IW'(i);
        grant_o = '0;
        grant_o[i] = 1'b1;
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_gie_seq.sv
module irq_gie_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic fire_i,
  input  logic reti_i,
  input  logic instr_i,
  output logic gie_o,
  output logic hold_o,
  output logic open_o
);
  logic gie_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (fire_i)      gie_q <= 1'b0;
      else if (reti_i) gie_q <= 1'b1;
      else if (clr_i)  gie_q <= 1'b0;
      else if (set_i)  gie_q <= 1'b1;
      if (reti_i)       hold_q <= 1'b1;
      else if (instr_i) hold_q <= 1'b0;
    end
  end

  assign gie_o  = gie_q;
  assign hold_o = hold_q;
  assign open_o = gie_q & ~clr_i & ~hold_q;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC = 8,
  parameter int AW = 12,
  parameter logic [AW-1:0] BOOT_BASE = 12'hC00,
  parameter logic [NSRC-1:0] LEVEL_MASK = '0,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt_i,
  input  logic [NSRC-1:0] src_en_i,
  input  logic [NSRC-1:0] w1c_i,
  input  logic            gie_set_i,
  input  logic            gie_clr_i,
  input  logic            ack_i,
  input  logic            reti_i,
  input  logic            instr_i,
  input  logic            boot_sel_i,
  output logic            irq_o,
  output logic [AW-1:0]   vec_o,
  output logic            gie_o,
  output logic [NSRC-1:0] flags_o
);
  // slot 0 is reset, source i lives in slot i+1, two words per slot
  function automatic logic [AW-1:0] vec_of(input logic [AW-1:0] base,
                                           input logic [IW-1:0] idx);
    logic [AW-1:0] slot;
    slot = AW'(idx) + AW'(1);
    return base + (slot << 1);
  endfunction

  logic [NSRC-1:0] pend_w, req_w, grant_w, take_w;
  logic [IW-1:0]   idx_w;
  logic            any_w, open_w, hold_w, fire_w;

  irq_flag_bank #(.NSRC(NSRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(src_evt_i), .w1c_i(w1c_i),
    .take_i(take_w), .pend_o(pend_w)
  );

  assign req_w = pend_w & src_en_i;

  irq_prio_sel #(.NSRC(NSRC)) u_sel (
    .req_i(req_w), .any_o(any_w), .idx_o(idx_w), .grant_o(grant_w)
  );

  irq_gie_seq u_gie (
    .clk(clk), .rst_n(rst_n), .set_i(gie_set_i), .clr_i(gie_clr_i),
    .fire_i(fire_w), .reti_i(reti_i), .instr_i(instr_i),
    .gie_o(gie_o), .hold_o(hold_w), .open_o(open_w)
  );

  assign irq_o   = any_w & open_w;
  assign fire_w  = ack_i & irq_o;
  assign take_w  = grant_w & {NSRC{fire_w}};
  assign vec_o   = vec_of(boot_sel_i ? BOOT_BASE : '0, idx_w);
  assign flags_o = pend_w;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int NSRC = 8,
  parameter int AW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_en_i,
  input logic            gie_clr_i,
  input logic            reti_i,
  input logic            irq_o,
  input logic [AW-1:0]   vec_o,
  input logic            gie_o,
  input logic [NSRC-1:0] flags_o,
  input logic [NSRC-1:0] take_w,
  input logic            fire_w
);
  a_r2_irq_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(flags_o & src_en_i)) && gie_o);
  a_r3_vector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o[0] == 1'b0));
  a_r5_single_take: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_w));
  a_r6_ack_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |=> !gie_o);
  a_r7_reti_holds: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i |=> gie_o && !irq_o);
  a_r8_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_i |-> !irq_o);
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_en_i(src_en_i), .gie_clr_i(gie_clr_i),
  .reti_i(reti_i), .irq_o(irq_o), .vec_o(vec_o), .gie_o(gie_o),
  .flags_o(flags_o), .take_w(take_w), .fire_w(fire_w)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  localparam int N = 4;
  localparam int AW = 10;
  localparam logic [AW-1:0] BB = 10'h300;
  localparam logic [N-1:0] LVL = 4'b1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] evt = '0, en = '0, w1c = '0;
  logic gset = 0, gclr = 0, ack = 0, reti = 0, instr = 0, bsel = 0;
  logic irq, gie;
  logic [AW-1:0] vec;
  logic [N-1:0] flags;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vec_irq_ctrl #(.NSRC(N), .AW(AW), .BOOT_BASE(BB), .LEVEL_MASK(LVL)) uut (
    .clk(clk), .rst_n(rst_n), .src_evt_i(evt), .src_en_i(en), .w1c_i(w1c),
    .gie_set_i(gset), .gie_clr_i(gclr), .ack_i(ack), .reti_i(reti),
    .instr_i(instr), .boot_sel_i(bsel), .irq_o(irq), .vec_o(vec),
    .gie_o(gie), .flags_o(flags)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int exp_vec(input int pe, input bit b);
    int base = b ? int'(BB) : 0;
    for (int i = 0; i < N; i++) if (pe[i]) return base + 2 * (i + 1);
    return base + 2;
  endfunction

  task automatic clean();
    w1c = '1; evt = '0; gset = 1; gclr = 0; ack = 0; reti = 0; instr = 1;
    tick();
    w1c = '0; gset = 0; instr = 0;
  endtask

  initial begin
    repeat (2) tick();
    check("R1 flags", flags, 0);
    check("R1 irq", irq, 0);
    check("R1 gie", gie, 0);
    rst_n = 1;
    tick();

    // sweep: R2, R3, R4 over all pending/enable/base combinations
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 16; p++)
        for (int e = 0; e < 16; e++) begin
          en = 4'(e); bsel = b[0];
          clean();
          evt = 4'(p);
          tick();
          evt = 4'(p) & LVL;
          #1;
          check("R4 flags", flags, p);
          check("R2 irq", irq, ((p & e) != 0) ? 1 : 0);
          if ((p & e) != 0) check("R3 vec", vec, exp_vec(p & e, b[0]));
        end

    // R4: event while globally disabled, then enable
    bsel = 0; en = '0; clean();
    gclr = 1; tick(); gclr = 0;
    evt = 4'b0100; tick(); evt = '0;
    repeat (3) tick();
    check("R4 held", flags, 4'b0100);
    check("R4 no irq", irq, 0);
    en = '1; gset = 1; tick(); gset = 0; #1;
    check("R4 irq", irq, 1);
    check("R4 vec", vec, 6);

    // R5/R6/R7: ack, return, one-instruction hold
    clean(); en = '1; evt = 4'b0011; tick(); evt = '0; #1;
    check("R3 vec", vec, 2);
    ack = 1; tick(); ack = 0; #1;
    check("R5 flags", flags, 4'b0010);
    check("R6 gie", gie, 0);
    check("R6 irq", irq, 0);
    reti = 1; tick(); reti = 0; #1;
    check("R7 gie", gie, 1);
    check("R7 hold", irq, 0);
    tick(); #1;
    check("R7 hold2", irq, 0);
    instr = 1; tick(); instr = 0; #1;
    check("R7 irq", irq, 1);
    check("R7 vec", vec, 4);

    // R8: clear in same cycle blocks at once
    gclr = 1; #1;
    check("R8 same", irq, 0);
    tick(); gclr = 0; #1;
    check("R8 gie", gie, 0);
    check("R8 irq", irq, 0);

    // R9: w1c alone clears, w1c with event keeps
    w1c = 4'b0010; tick(); w1c = '0; #1;
    check("R9 clr", flags, 0);
    w1c = 4'b0001; evt = 4'b0001; tick(); w1c = '0; evt = '0; #1;
    check("R9 race", flags, 4'b0001);

    // R10: vanished level condition leaves nothing
    clean(); en = '0; evt = 4'b1000; tick(); #1;
    check("R10 live", flags, 4'b1000);
    evt = '0; tick(); en = '1; #1;
    check("R10 flags", flags, 0);
    check("R10 irq", irq, 0);
    // R5: ack on level source leaves condition visible
    evt = 4'b1000; #1;
    check("R10 vec", vec, 8);
    ack = 1; tick(); ack = 0; #1;
    check("R5 level", flags, 4'b1000);
    check("R6 gie2", gie, 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule